// File: doc/BRIEF.md
# Scrolling Scan Line Address Generator

This block produces the display memory row address that is fetched for each common (row) drive period while a panel is being refreshed. A line counter advances once per common-cycle tick. It returns to zero when the frame-polarity signal switches, and also when it passes the last row of memory. The counter value is added to a programmable start line, and the sum is reduced modulo the number of memory rows. The result is the row shown on the current scan line.

A host writes a new 9-bit start line through a set-start-line strobe. The whole picture then moves vertically and the memory is not rewritten. The written value is held as pending and becomes active only at the next frame-polarity switch, so a frame that is already being scanned is never split between two offsets.

Top module: `scan_addr_gen`

## Requirements
- R1: During reset and right after reset release, the line count and active start line are zero, so `row_addr` is 0.
- R2: A `line_tick` pulse with no `fr_toggle` in the same cycle advances `row_addr` by one, modulo ROWS, from the next cycle on.
- R3: Without an `fr_toggle`, the line count wraps to zero after ROWS-1, so after ROWS ticks `row_addr` returns to the start line.
- R4: An `fr_toggle` pulse clears the line count, so `row_addr` equals the active start line in the next cycle; `fr_toggle` takes priority over a simultaneous `line_tick`.
- R5: A `start_wr` pulse without `fr_toggle` has no effect on `row_addr`.
- R6: At each `fr_toggle`, the most recently written start value becomes active; a write in the same cycle as the `fr_toggle` is the one applied.
- R7: A written start value of ROWS or more is stored reduced modulo ROWS (with ROWS=264, a write of 500 acts as 236).
- R8: `row_addr` always equals (active start + line count) modulo ROWS, and is always below ROWS.
- R9: In a cycle with no `line_tick` and no `fr_toggle`, `row_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_tick | input | 1 | One-cycle pulse per common drive period |
| fr_toggle | input | 1 | One-cycle pulse at each frame-polarity switch |
| start_wr | input | 1 | Set-start-line strobe |
| start_val | input | AW (9) | Start line value written with `start_wr` |
| row_addr | output | AW (9) | Memory row address for the current scan line |

## Verification
A corrupted line count shows up as a wrong `row_addr` in the very next cycle, and it stays wrong until the next `fr_toggle` clears it. The bench compares the output after every clock against its own reference. A bad pending or active start register is seen only after a frame event, so the stimulus writes start values at varied distances from `fr_toggle`, including in the same cycle. The modulo path is tested by walking the counter across the wrap with start values near ROWS, and by writing out-of-range start values.

// File: rtl/scan_addr_pkg.sv
package scan_addr_pkg;
  localparam int DEF_ROWS = 264;
  localparam int DEF_AW   = 9;

  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_CLEAR = 2'd1,
    CNT_STEP  = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/start_line_reduce.sv
module start_line_reduce #(
  parameter int ROWS = 264,
  parameter int AW   = 9
) (
  input  logic [AW-1:0] raw_val,
  output logic [AW-1:0] red_val
);
  localparam int STAGES = ((1 << AW) + ROWS - 1) / ROWS;
  localparam logic [AW:0] ROWS_X = (AW+1)'(ROWS);

  logic [AW:0] chain [STAGES+1];

  assign chain[0] = {1'b0, raw_val};

  for (genvar g = 0; g < STAGES; g++) begin : g_sub
    always_comb begin
      if (chain[g] >= ROWS_X) chain[g+1] = chain[g] - ROWS_X;
      else                    chain[g+1] = chain[g];
    end
  end

  assign red_val = chain[STAGES][AW-1:0];
endmodule

// File: rtl/start_line_regs.sv
module start_line_regs #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_val,
  input  logic          frame_evt,
  output logic [AW-1:0] start_act
);
  logic [AW-1:0] pend_q, pend_d;
  logic [AW-1:0] act_q, act_d;
  logic          pend_en, act_en;

  always_comb begin
    pend_en = wr_en;
    pend_d  = wr_val;
    act_en  = frame_evt;
    act_d   = wr_en ? wr_val : pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= '0;
    else if (act_en) act_q <= act_d;
  end

  assign start_act = act_q;
endmodule

// File: rtl/scan_line_counter.sv
module scan_line_counter
  import scan_addr_pkg::*;
#(
  parameter int ROWS = 264,
  parameter int AW   = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_tick,
  input  logic          frame_evt,
  output logic [AW-1:0] count
);
  localparam logic [AW-1:0] LAST = AW'(ROWS - 1);

  cnt_act_e      act;
  logic [AW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    if (frame_evt)      act = CNT_CLEAR;
    else if (line_tick) act = CNT_STEP;
    else                act = CNT_HOLD;
  end

  always_comb begin
    cnt_en = (act != CNT_HOLD);
    unique case (act)
      CNT_CLEAR: cnt_d = '0;
      CNT_STEP:  cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
  import scan_addr_pkg::*;
#(
  parameter int ROWS = DEF_ROWS,
  parameter int AW   = DEF_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_tick,
  input  logic          fr_toggle,
  input  logic          start_wr,
  input  logic [AW-1:0] start_val,
  output logic [AW-1:0] row_addr
);
  localparam logic [AW:0] ROWS_X = (AW+1)'(ROWS);

  logic          rst_n_sync;
  logic [AW-1:0] start_red;
  logic [AW-1:0] start_act;
  logic [AW-1:0] line_cnt;
  logic [AW:0]   sum;

  scan_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  start_line_reduce #(.ROWS(ROWS), .AW(AW)) u_red (
    .raw_val (start_val),
    .red_val (start_red)
  );

  start_line_regs #(.AW(AW)) u_start (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .wr_en     (start_wr),
    .wr_val    (start_red),
    .frame_evt (fr_toggle),
    .start_act (start_act)
  );

  scan_line_counter #(.ROWS(ROWS), .AW(AW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .line_tick (line_tick),
    .frame_evt (fr_toggle),
    .count     (line_cnt)
  );

  always_comb begin
    sum = {1'b0, start_act} + {1'b0, line_cnt};
    if (sum >= ROWS_X) row_addr = AW'(sum - ROWS_X);
    else               row_addr = sum[AW-1:0];
  end
endmodule

// File: rtl/scan_addr_gen_chk.sv
module scan_addr_gen_chk #(
  parameter int ROWS = 264,
  parameter int AW   = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_tick,
  input logic          fr_toggle,
  input logic          start_wr,
  input logic [AW-1:0] start_act,
  input logic [AW-1:0] row_addr
);
  // R8
  row_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(row_addr) < ROWS);

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && !fr_toggle) |=>
      int'(row_addr) == ((int'($past(row_addr)) + 1) % ROWS));

  // R4
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fr_toggle |=> row_addr == start_act);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_tick && !fr_toggle) |=> $stable(row_addr));

  // R5
  start_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fr_toggle |=> $stable(start_act));
endmodule

bind scan_addr_gen scan_addr_gen_chk #(.ROWS(ROWS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .line_tick (line_tick),
  .fr_toggle (fr_toggle),
  .start_wr  (start_wr),
  .start_act (start_act),
  .row_addr  (row_addr)
);

// File: tb/scan_addr_gen_tb.sv
module scan_addr_gen_tb;
  localparam int ROWS = 264;
  localparam int AW   = 9;

  logic          clk;
  logic          rst_n;
  logic          line_tick;
  logic          fr_toggle;
  logic          start_wr;
  logic [AW-1:0] start_val;
  logic [AW-1:0] row_addr;

  int tests, fails;
  int m_cnt, m_act, m_pend;

  scan_addr_gen #(.ROWS(ROWS), .AW(AW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_tick (line_tick),
    .fr_toggle (fr_toggle),
    .start_wr  (start_wr),
    .start_val (start_val),
    .row_addr  (row_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int exp_addr();
    return (m_act + m_cnt) % ROWS;
  endfunction

  task automatic check(input string tag, input int exp_v);
    tests++;
    if (int'(row_addr) != exp_v) begin
      fails++;
      $display("FAIL %s: row_addr=%0d expected=%0d", tag, row_addr, exp_v);
    end
  endtask

  task automatic cyc(input bit t, input bit f, input bit w, input int v,
                     input string tag);
    start_val = AW'(v);
    line_tick = t;
    fr_toggle = f;
    start_wr  = w;
    @(posedge clk);
    if (f) begin
      m_act = w ? (v % ROWS) : m_pend;
      m_cnt = 0;
    end else if (t) begin
      m_cnt = (m_cnt + 1) % ROWS;
    end
    if (w) m_pend = v % ROWS;
    @(negedge clk);
    check(tag, exp_addr());
  endtask

  initial begin
    tests = 0; fails = 0;
    #4_000_000;
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5CA1_0042;
    void'($urandom(seed));
    m_cnt = 0; m_act = 0; m_pend = 0;
    line_tick = 0; fr_toggle = 0; start_wr = 0; start_val = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 after release", 0);

    // R2: ticks advance
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, "R2");
    // R9: idle holds
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, "R9");
    // R5: write hidden until frame event
    cyc(0, 0, 1, 260, "R5");
    cyc(1, 0, 0, 0, "R5");
    check("R5 not yet active", 6);
    // R6 + R4: frame event applies pending, clears count (priority over tick)
    cyc(1, 1, 0, 0, "R4/R6");
    check("R6 active start", 260);
    // R3 + R2 wrap across ROWS
    for (int i = 0; i < ROWS; i++) cyc(1, 0, 0, 0, "R3");
    check("R3 back to start", 260);
    // R6: write in same cycle as frame event
    cyc(0, 0, 1, 10, "R6");
    cyc(0, 1, 1, 77, "R6 same cycle");
    check("R6 same-cycle value", 77);
    // R7: out-of-range values
    cyc(0, 0, 1, 500, "R7");
    cyc(0, 1, 0, 0, "R7");
    check("R7 500 mod ROWS", 236);
    cyc(0, 0, 1, 264, "R7");
    cyc(0, 1, 0, 0, "R7");
    check("R7 264 mod ROWS", 0);
    cyc(0, 0, 1, 511, "R7");
    cyc(1, 1, 0, 0, "R7");
    check("R7 511 mod ROWS", 247);

    // R8: constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(99, 0));
      cyc(r < 60, r >= 97, ($urandom_range(19, 0) == 0),
          int'($urandom_range(511, 0)), "R8");
    end

    line_tick = 0; fr_toggle = 0; start_wr = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule